// File: doc/BRIEF.md
# Bidirectional Handshake Parallel Port

This block is one parallel port whose peripheral bus carries bytes both ways. A peripheral that sends data presents a byte and pulses an active-low strobe. The port marks its input buffer full and keeps the byte until the host reads it. A host byte written to the port raises an active-low output-buffer-full flag. The peripheral then pulls an active-low acknowledge to take that byte. The port drives the shared bus only while acknowledge is low. At all other times it leaves the bus floating, which the block shows as an output-enable.

A single interrupt line serves both directions, and each direction has its own enable bit. The input side asks for service when a byte waits and neither strobe nor read is active. The output side asks for service when the output buffer is empty and neither acknowledge nor write is active. The host side is synchronous to the block clock. A one-bit address selects either the data path or the control word that holds the two enable bits. Strobe, acknowledge and peripheral data arrive from outside the clock domain, so they pass through a synchronizer of configurable depth.

Top module: `hsport_bidir`

## Requirements
- R1: While `rst_n` is low and afterwards until new stimulus arrives, `in_full` is 0, `out_full_n` is 1, `irq` is 0, `per_oe` is 0 and both interrupt enables read back as 0.
- R2: A falling edge of the synchronized `per_stb_n` sets `in_full` to 1.
- R3: A rising edge of the synchronized `per_stb_n` captures the synchronized `per_din` into the input latch. A host read with `host_addr`=0 returns that byte on `host_rdata` while `host_rd_n` is low.
- R4: The rising edge of `host_rd_n` with `host_addr`=0 clears `in_full`. A read with `host_addr`=1 leaves `in_full` unchanged.
- R5: The rising edge of `host_wr_n` with `host_addr`=0 stores `host_wdata` in the output latch and drives `out_full_n` to 0.
- R6: A falling edge of the synchronized `per_ack_n` sets `out_full_n` back to 1.
- R7: `per_oe` is a registered copy of "synchronized `per_ack_n` is low". `per_dout` always carries the output latch.
- R8: `irq` is a register equal to (in_full AND input enable AND strobe high AND `host_rd_n` high) OR (`out_full_n` AND output enable AND acknowledge high AND `host_wr_n` high).
- R9: The rising edge of `host_wr_n` with `host_addr`=1 loads the control word, with bit 0 as the input interrupt enable and bit 1 as the output interrupt enable. A read with `host_addr`=1 returns the control word with its upper bits zero.
- R10: The input latch and the output latch are separate. A strobe that arrives while an output byte is pending corrupts neither that byte nor `out_full_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 1 | 0 selects data, 1 selects the control word |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| per_din | input | DATA_W | Byte on the shared bus, as seen by the port |
| per_dout | output | DATA_W | Byte the port offers to the shared bus |
| per_oe | output | 1 | Port drives the shared bus while high |
| per_stb_n | input | 1 | Peripheral strobe, active low |
| per_ack_n | input | 1 | Peripheral acknowledge, active low |
| in_full | output | 1 | Input buffer full |
| out_full_n | output | 1 | Output buffer full, active low |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with `DATA_W`=8 and `SYNC_STAGES`=2. With a two-stage synchronizer, every peripheral edge settles within a few cycles, so the bench can run strobe, acknowledge, read and write orderings back to back. With full bytes, the bench can use patterns that tell the input latch apart from the output latch and from the control word. It sends an input strobe while an output byte is pending. This exercises the interleaving in which the two latches could be confused.

// File: rtl/hsport_pkg.sv
// Package: shared address decode for the handshake port.
// Assumes a one-bit host address selecting data or control.
package hsport_pkg;
    typedef enum logic {
        ADDR_DATA = 1'b0,
        ADDR_CTRL = 1'b1
    } hsport_addr_e;

    // Bit positions inside the control word.
    localparam int CTRL_IN_EN_BIT  = 0;
    localparam int CTRL_OUT_EN_BIT = 1;
endpackage

// File: rtl/hsport_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 1; every bit passes through the same number of flops,
// so bits that change together stay aligned at the output.
module hsport_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_multi
            // Purpose: shift the input through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsport_in_ch.sv
// Module: input half of the port. Sets the full flag on a strobe fall,
// captures data on a strobe rise, and clears the flag on a host data read.
// Assumes stb_s and din_s are already synchronized and aligned.
module hsport_in_ch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_s,
    input  logic [DATA_W-1:0] din_s,
    input  logic              rd_done,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    logic stb_prev;
    logic stb_fall;
    logic stb_rise;

    assign stb_fall = stb_prev & ~stb_s;
    assign stb_rise = ~stb_prev & stb_s;

    // Purpose: remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= 1'b1;
        else        stb_prev <= stb_s;
    end

    // Purpose: full flag, where a new strobe wins over a read ending in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        full <= 1'b0;
        else if (stb_fall) full <= 1'b1;
        else if (rd_done)  full <= 1'b0;
    end

    // Purpose: input latch, loaded at the strobe's rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (stb_rise) data <= din_s;
    end
endmodule

// File: rtl/hsport_out_ch.sv
// Module: output half of the port. A host data write loads the latch and
// marks the buffer full; the acknowledge fall empties it; the bus is
// enabled one cycle after the synchronized acknowledge goes low.
// Assumes ack_s is already synchronized.
module hsport_out_ch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_s,
    input  logic              wr_done,
    input  logic [DATA_W-1:0] wdata,
    output logic              full_n,
    output logic [DATA_W-1:0] data,
    output logic              oe
);
    logic ack_prev;
    logic ack_fall;

    assign ack_fall = ack_prev & ~ack_s;

    // Purpose: remember the previous acknowledge level.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_prev <= 1'b1;
        else        ack_prev <= ack_s;
    end

    // Purpose: buffer-full flag, where a new write wins over an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        full_n <= 1'b1;
        else if (wr_done)  full_n <= 1'b0;
        else if (ack_fall) full_n <= 1'b1;
    end

    // Purpose: output latch, loaded when a host data write ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       data <= '0;
        else if (wr_done) data <= wdata;
    end

    // Purpose: bus drive window follows the acknowledge-low condition.
    always_ff @(posedge clk) begin
        if (!rst_n) oe <= 1'b0;
        else        oe <= ~ack_s;
    end
endmodule

// File: rtl/hsport_bidir.sv
// Module: top of the bidirectional handshake port. Synchronizes the
// peripheral side, detects host strobe ends, holds the control word and
// forms the merged interrupt.
// Assumes host strobes, address and write data are synchronous to clk and
// that address and data stay valid through the cycle a strobe rises.
module hsport_bidir
    import hsport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] per_din,
    output logic [DATA_W-1:0] per_dout,
    output logic              per_oe,
    input  logic              per_stb_n,
    input  logic              per_ack_n,
    output logic              in_full,
    output logic              out_full_n,
    output logic              irq
);
    localparam int SYNC_W = DATA_W + 2;

    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic [DATA_W-1:0] din_s;
    logic              stb_s;
    logic              ack_s;
    logic              rd_q;
    logic              wr_q;
    logic              rd_rise;
    logic              wr_rise;
    logic              mask_in;
    logic              mask_out;
    logic [DATA_W-1:0] in_data;
    logic [DATA_W-1:0] ctrl_word;

    assign sync_in = {per_ack_n, per_stb_n, per_din};
    assign din_s   = sync_out[DATA_W-1:0];
    assign stb_s   = sync_out[DATA_W];
    assign ack_s   = sync_out[DATA_W+1];

    hsport_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({2'b11, {DATA_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    // Purpose: delayed host strobes for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= host_rd_n;
            wr_q <= host_wr_n;
        end
    end

    assign rd_rise = ~rd_q & host_rd_n;
    assign wr_rise = ~wr_q & host_wr_n;

    hsport_in_ch #(.DATA_W(DATA_W)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_s   (stb_s),
        .din_s   (din_s),
        .rd_done (rd_rise & (host_addr == ADDR_DATA)),
        .full    (in_full),
        .data    (in_data)
    );

    hsport_out_ch #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_s   (ack_s),
        .wr_done (wr_rise & (host_addr == ADDR_DATA)),
        .wdata   (host_wdata),
        .full_n  (out_full_n),
        .data    (per_dout),
        .oe      (per_oe)
    );

    // Purpose: control word holding the two interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_in  <= 1'b0;
            mask_out <= 1'b0;
        end else if (wr_rise && host_addr == ADDR_CTRL) begin
            mask_in  <= host_wdata[CTRL_IN_EN_BIT];
            mask_out <= host_wdata[CTRL_OUT_EN_BIT];
        end
    end

    // Purpose: merged interrupt from the two masked handshake conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (in_full & mask_in & stb_s & host_rd_n)
                         | (out_full_n & mask_out & ack_s & host_wr_n);
    end

    // Purpose: assemble the readable control word.
    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[CTRL_IN_EN_BIT]  = mask_in;
        ctrl_word[CTRL_OUT_EN_BIT] = mask_out;
    end

    // Purpose: host read data select.
    assign host_rdata = (host_addr == ADDR_CTRL) ? ctrl_word : in_data;
endmodule

// File: rtl/hsport_bidir_chk.sv
// Module: assertion checker for hsport_bidir, attached with bind.
// Assumes it sees the synchronized strobe and acknowledge of the top.
module hsport_bidir_chk (
    input logic clk,
    input logic rst_n,
    input logic host_addr,
    input logic host_rd_n,
    input logic host_wr_n,
    input logic stb_s,
    input logic ack_s,
    input logic in_full,
    input logic out_full_n,
    input logic per_oe,
    input logic irq,
    input logic mask_in,
    input logic mask_out
);
    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_s) |=> in_full);

    // R4
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_rd_n) && host_addr == 1'b0 && !$fell(stb_s)) |=> !in_full);

    // R5
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(host_wr_n) && host_addr == 1'b0) |=> !out_full_n);

    // R6
    obf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_s) && !($rose(host_wr_n) && host_addr == 1'b0)) |=> out_full_n);

    // R7
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_oe |-> $past(!ack_s));

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mask_in || mask_out));

    // R8
    irq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd_n && !mask_out) |=> !irq);
endmodule

bind hsport_bidir hsport_bidir_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_rd_n  (host_rd_n),
    .host_wr_n  (host_wr_n),
    .stb_s      (stb_s),
    .ack_s      (ack_s),
    .in_full    (in_full),
    .out_full_n (out_full_n),
    .per_oe     (per_oe),
    .irq        (irq),
    .mask_in    (mask_in),
    .mask_out   (mask_out)
);

// File: tb/hsport_bidir_bench.sv
module hsport_bidir_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_addr = 1'b0;
    logic          host_rd_n = 1'b1;
    logic          host_wr_n = 1'b1;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [DW-1:0] per_din = '0;
    logic [DW-1:0] per_dout;
    logic          per_oe;
    logic          per_stb_n = 1'b1;
    logic          per_ack_n = 1'b1;
    logic          in_full;
    logic          out_full_n;
    logic          irq;

    always #2 clk = ~clk;

    hsport_bidir #(.DATA_W(DW), .SYNC_STAGES(2)) u_hsport_bidir (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .per_din    (per_din),
        .per_dout   (per_dout),
        .per_oe     (per_oe),
        .per_stb_n  (per_stb_n),
        .per_ack_n  (per_ack_n),
        .in_full    (in_full),
        .out_full_n (out_full_n),
        .irq        (irq)
    );

    typedef enum int {S_RDATA, S_IBF, S_OBFN, S_IRQ, S_OE, S_DOUT} sig_e;
    typedef struct {
        sig_e          sig;
        logic [DW-1:0] exp;
        string         req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    // Driver side: queue an expectation; the monitor compares it at the next falling edge.
    task automatic expect_val(sig_e s, logic [DW-1:0] e, string r);
        item_t it;
        it.sig = s; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    function automatic logic [DW-1:0] pick(sig_e s);
        case (s)
            S_RDATA: return host_rdata;
            S_IBF:   return {{(DW-1){1'b0}}, in_full};
            S_OBFN:  return {{(DW-1){1'b0}}, out_full_n};
            S_IRQ:   return {{(DW-1){1'b0}}, irq};
            S_OE:    return {{(DW-1){1'b0}}, per_oe};
            default: return per_dout;
        endcase
    endfunction

    // Monitor: pops expectations and compares them away from the rising edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [DW-1:0] act;
            it = q.pop_front();
            act = pick(it.sig);
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s %s actual=%h expected=%h", it.req, it.sig.name(), act, it.exp);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic host_write(logic a, logic [DW-1:0] d);
        host_addr = a; host_wdata = d; host_wr_n = 1'b0;
        cyc(2);
        host_wr_n = 1'b1;
        cyc(2);
    endtask

    task automatic strobe(logic [DW-1:0] d);
        per_din = d; per_stb_n = 1'b0;
        cyc(6);
        per_stb_n = 1'b1;
        cyc(6);
    endtask

    initial begin
        cyc(4);
        // R1 reset state
        expect_val(S_IBF, 0, "R1"); expect_val(S_OBFN, 1, "R1");
        expect_val(S_IRQ, 0, "R1"); expect_val(S_OE, 0, "R1");
        host_addr = 1'b1;
        expect_val(S_RDATA, 8'h00, "R1");
        cyc(1);
        rst_n = 1'b1;
        cyc(2);
        expect_val(S_IBF, 0, "R1"); expect_val(S_OBFN, 1, "R1");
        cyc(1);

        // R9 enable input interrupt only, read back the control word
        host_write(1'b1, 8'hFD);
        host_addr = 1'b1; host_rd_n = 1'b0;
        cyc(2);
        expect_val(S_RDATA, 8'h01, "R9");
        host_rd_n = 1'b1;
        cyc(2);
        expect_val(S_IRQ, 0, "R8");

        // R2/R3 strobed input with data A5
        per_din = 8'hA5; per_stb_n = 1'b0;
        cyc(6);
        expect_val(S_IBF, 1, "R2");
        expect_val(S_IRQ, 0, "R8");
        per_stb_n = 1'b1;
        cyc(6);
        expect_val(S_IRQ, 1, "R8");
        // R4 control read leaves the flag set
        host_addr = 1'b1; host_rd_n = 1'b0;
        cyc(2);
        host_rd_n = 1'b1;
        cyc(2);
        expect_val(S_IBF, 1, "R4");
        host_addr = 1'b0; host_rd_n = 1'b0;
        cyc(2);
        expect_val(S_RDATA, 8'hA5, "R3");
        expect_val(S_IRQ, 0, "R8");
        host_rd_n = 1'b1;
        cyc(2);
        expect_val(S_IBF, 0, "R4");
        expect_val(S_IRQ, 0, "R8");

        // R8 input masked off
        host_write(1'b1, 8'h00);
        strobe(8'h3C);
        expect_val(S_IBF, 1, "R2");
        expect_val(S_IRQ, 0, "R8");
        host_addr = 1'b0; host_rd_n = 1'b0;
        cyc(2);
        expect_val(S_RDATA, 8'h3C, "R3");
        host_rd_n = 1'b1;
        cyc(2);

        // R5/R6/R7 strobed output with output enable only
        host_write(1'b1, 8'h02);
        cyc(1);
        expect_val(S_IRQ, 1, "R8");
        host_addr = 1'b0; host_wdata = 8'h5A; host_wr_n = 1'b0;
        cyc(2);
        expect_val(S_IRQ, 0, "R8");
        host_wr_n = 1'b1;
        cyc(2);
        expect_val(S_OBFN, 0, "R5");
        expect_val(S_OE, 0, "R7");
        expect_val(S_IRQ, 0, "R8");
        per_ack_n = 1'b0;
        cyc(6);
        expect_val(S_OE, 1, "R7");
        expect_val(S_DOUT, 8'h5A, "R5");
        expect_val(S_OBFN, 1, "R6");
        expect_val(S_IRQ, 0, "R8");
        per_ack_n = 1'b1;
        cyc(6);
        expect_val(S_OE, 0, "R7");
        expect_val(S_IRQ, 1, "R8");

        // R10 interleave: output pending while an input strobe arrives
        host_write(1'b1, 8'h03);
        host_write(1'b0, 8'h77);
        expect_val(S_OBFN, 0, "R10");
        strobe(8'h99);
        expect_val(S_OBFN, 0, "R10");
        expect_val(S_IBF, 1, "R10");
        expect_val(S_DOUT, 8'h77, "R10");
        expect_val(S_IRQ, 1, "R8");
        per_ack_n = 1'b0;
        cyc(6);
        expect_val(S_OE, 1, "R10");
        expect_val(S_DOUT, 8'h77, "R10");
        per_ack_n = 1'b1;
        cyc(6);
        host_addr = 1'b0; host_rd_n = 1'b0;
        cyc(2);
        expect_val(S_RDATA, 8'h99, "R10");
        host_rd_n = 1'b1;
        cyc(2);
        expect_val(S_IBF, 0, "R4");
        expect_val(S_IRQ, 1, "R8");
        cyc(2);
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    failures++;
                    $display("FAIL watchdog actual=running expected=done");
                end
            end
            begin
                wait (done);
            end
        join_any
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule